// File: doc/BRIEF.md
# Bit-serial pixel enable unit

This block is one processing element of a bit-serial pixel array. It holds 256 one-bit memory cells, one enable flag and one carry bit. Each clock it can take one instruction word. The word carries an opcode in bits 15:8, a bit address in bits 7:0 and a modifier in bit 16. The instruction either changes the enable flag from a memory bit or writes a memory bit from the enable flag or the carry. Conditional execution across the array is done through the enable flag alone. The opcodes here are the ones that set, clear, load, AND, XOR and store that flag, including forms that use the inverse of the memory bit.

A host port reads memory bits directly and writes them one at a time, and it can preset the carry bit. This is the port for test access and for seeding data. Instructions that write memory do so whatever the enable flag holds. An opcode the unit does not recognise changes nothing and raises a sticky error flag.

Top module: `pe_enable_unit`

## Requirements
- R1: After reset, enable_o is 1, carry_o is 0, err_o is 0 and all 256 memory bits read 0.
- R2: Word 0x100 (opcode 0x01) sets the enable flag. Word 0x200 (opcode 0x02) clears it.
- R3: Opcode 0x03 loads the enable flag from the addressed memory bit. Opcode 0x48 loads it from the inverse of that bit.
- R4: Opcode 0x05 ANDs the enable flag with the addressed bit. Opcode 0x08 ANDs it with the inverse of that bit.
- R5: Opcode 0x0A with bit 16 set (word 0x10A00 | addr) XORs the enable flag with the addressed bit. Opcode 0x0A with bit 16 clear is unknown.
- R6: Opcode 0xB5 writes the enable flag into the addressed bit, and opcode 0xB3 writes the carry into it. Both write even while the enable flag is 0.
- R7: Opcode 0xB7 ORs the enable flag into the addressed bit, and opcode 0xB9 ANDs it in. Both write even while the enable flag is 0.
- R8: The bit address is word bits 7:0 and the opcode is bits 15:8. Bit 16 must be 0 for every opcode except 0x0A. Bits 31:17 are ignored.
- R9: An unknown opcode/bit-16 combination leaves the enable flag, the carry and the memory unchanged and sets err_o. err_o then stays 1 until reset.
- R10: Every instruction completes on the clock edge that takes it, so the next instruction sees its result. With instr_valid_i low the word is ignored.
- R11: host_rdata_o shows the bit at host_addr_i combinationally. host_we_i writes host_wdata_i there on the clock edge. host_carry_we_i loads host_carry_i into the carry.
- R12: When the host port and an instruction write the same bit in one cycle, the instruction's value is kept. An instruction that reads a bit the host writes in the same cycle sees the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| host_we_i | input | 1 | Host bit write strobe |
| host_addr_i | input | 8 | Host bit address for read and write |
| host_wdata_i | input | 1 | Host write data |
| host_rdata_o | output | 1 | Memory bit at host_addr_i |
| host_carry_we_i | input | 1 | Carry preset strobe |
| host_carry_i | input | 1 | Carry preset value |
| enable_o | output | 1 | Enable flag |
| carry_o | output | 1 | Carry bit |
| err_o | output | 1 | Sticky unknown-opcode flag |

## Verification
A host bit write and an instruction that reads or writes a memory bit can fall in the same cycle. The bench forces this in directed steps, where a host write and an enable store hit one address, and a host write lands on the bit a load instruction reads. It also lets random host writes land on the instruction's address. The expected result is that the instruction's write wins and the instruction reads the value from before the host write. The bench judges this by reading the bit back through the host port and by sampling the enable flag after the edge.

// File: rtl/pe_enable_pkg.sv
package pe_enable_pkg;
  typedef enum logic [3:0] {
    K_NOP, K_SET, K_CLR, K_LD, K_LDN, K_AND, K_ANDN, K_XOR,
    K_ST_EN, K_ST_CRY, K_OR_EN, K_AND_EN, K_ILLEGAL
  } op_kind_e;

  // decode key = {word[16], word[15:8]}
  localparam logic [8:0] KEY_SET    = 9'h001;
  localparam logic [8:0] KEY_CLR    = 9'h002;
  localparam logic [8:0] KEY_LD     = 9'h003;
  localparam logic [8:0] KEY_LDN    = 9'h048;
  localparam logic [8:0] KEY_AND    = 9'h005;
  localparam logic [8:0] KEY_ANDN   = 9'h008;
  localparam logic [8:0] KEY_XOR    = 9'h10A;
  localparam logic [8:0] KEY_ST_EN  = 9'h0B5;
  localparam logic [8:0] KEY_ST_CRY = 9'h0B3;
  localparam logic [8:0] KEY_OR_EN  = 9'h0B7;
  localparam logic [8:0] KEY_AND_EN = 9'h0B9;
endpackage

// File: rtl/pe_decode.sv
module pe_decode
  import pe_enable_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output op_kind_e          kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OP_LSB = 8;
  localparam int MOD_BIT = 16;

  logic [8:0] key;

  assign key    = {word_i[MOD_BIT], word_i[OP_LSB+7:OP_LSB]};
  assign addr_o = word_i[ADDR_W-1:0];

  always_comb begin
    if (!valid_i) begin
      kind_o = K_NOP;
    end else begin
      case (key)
        KEY_SET:    kind_o = K_SET;
        KEY_CLR:    kind_o = K_CLR;
        KEY_LD:     kind_o = K_LD;
        KEY_LDN:    kind_o = K_LDN;
        KEY_AND:    kind_o = K_AND;
        KEY_ANDN:   kind_o = K_ANDN;
        KEY_XOR:    kind_o = K_XOR;
        KEY_ST_EN:  kind_o = K_ST_EN;
        KEY_ST_CRY: kind_o = K_ST_CRY;
        KEY_OR_EN:  kind_o = K_OR_EN;
        KEY_AND_EN: kind_o = K_AND_EN;
        default:    kind_o = K_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/pe_enable_logic.sv
module pe_enable_logic
  import pe_enable_pkg::*;
(
  input  op_kind_e kind_i,
  input  logic     mem_bit_i,
  input  logic     en_i,
  input  logic     carry_i,
  output logic     en_next_o,
  output logic     mem_we_o,
  output logic     mem_wdata_o,
  output logic     illegal_o
);
  always_comb begin
    en_next_o   = en_i;
    mem_we_o    = 1'b0;
    mem_wdata_o = 1'b0;
    illegal_o   = 1'b0;
    unique case (kind_i)
      K_SET:    en_next_o = 1'b1;
      K_CLR:    en_next_o = 1'b0;
      K_LD:     en_next_o = mem_bit_i;
      K_LDN:    en_next_o = ~mem_bit_i;
      K_AND:    en_next_o = en_i & mem_bit_i;
      K_ANDN:   en_next_o = en_i & ~mem_bit_i;
      K_XOR:    en_next_o = en_i ^ mem_bit_i;
      // memory writes are not gated by the enable flag
      K_ST_EN:  begin mem_we_o = 1'b1; mem_wdata_o = en_i;             end
      K_ST_CRY: begin mem_we_o = 1'b1; mem_wdata_o = carry_i;          end
      K_OR_EN:  begin mem_we_o = 1'b1; mem_wdata_o = mem_bit_i | en_i; end
      K_AND_EN: begin mem_we_o = 1'b1; mem_wdata_o = mem_bit_i & en_i; end
      K_ILLEGAL: illegal_o = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/pe_bit_mem.sv
module pe_bit_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wdata_i,
  input  logic              ins_we_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              ins_wdata_i,
  output logic              host_rbit_o,
  output logic              ins_rbit_o,
  output logic [(1<<ADDR_W)-1:0] bits_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem_q;

  // instruction write is issued last so it wins a same-address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      if (host_we_i) mem_q[host_addr_i] <= host_wdata_i;
      if (ins_we_i)  mem_q[ins_addr_i]  <= ins_wdata_i;
    end
  end

  assign host_rbit_o = mem_q[host_addr_i];
  assign ins_rbit_o  = mem_q[ins_addr_i];
  assign bits_o      = mem_q;
endmodule

// File: rtl/pe_enable_unit.sv
module pe_enable_unit
  import pe_enable_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wdata_i,
  output logic              host_rdata_o,
  input  logic              host_carry_we_i,
  input  logic              host_carry_i,
  output logic              enable_o,
  output logic              carry_o,
  output logic              err_o
);
  localparam int DEPTH = 1 << ADDR_W;

  op_kind_e          kind;
  logic [ADDR_W-1:0] ins_addr;
  logic              ins_rbit;
  logic              en_q, en_next;
  logic              carry_q;
  logic              err_q;
  logic              ins_we, ins_wdata, illegal;
  logic [DEPTH-1:0]  mem_bits;

  pe_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) decode_i (
    .valid_i (instr_valid_i),
    .word_i  (instr_i),
    .kind_o  (kind),
    .addr_o  (ins_addr)
  );

  pe_enable_logic logic_i (
    .kind_i      (kind),
    .mem_bit_i   (ins_rbit),
    .en_i        (en_q),
    .carry_i     (carry_q),
    .en_next_o   (en_next),
    .mem_we_o    (ins_we),
    .mem_wdata_o (ins_wdata),
    .illegal_o   (illegal)
  );

  pe_bit_mem #(.ADDR_W(ADDR_W)) mem_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .ins_we_i     (ins_we),
    .ins_addr_i   (ins_addr),
    .ins_wdata_i  (ins_wdata),
    .host_rbit_o  (host_rdata_o),
    .ins_rbit_o   (ins_rbit),
    .bits_o       (mem_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      carry_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      en_q <= en_next;
      if (host_carry_we_i) carry_q <= host_carry_i;
      if (illegal) err_q <= 1'b1;
    end
  end

  assign enable_o = en_q;
  assign carry_o  = carry_q;
  assign err_o    = err_q;
endmodule

// File: rtl/pe_enable_unit_chk.sv
module pe_enable_unit_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   instr_valid_i,
  input logic [WORD_W-1:0]      instr_i,
  input logic                   host_we_i,
  input logic                   host_carry_we_i,
  input logic                   enable_o,
  input logic                   carry_o,
  input logic                   err_o,
  input logic [(1<<ADDR_W)-1:0] mem_bits
);
  logic [8:0] key;
  logic       known;
  assign key = {instr_i[16], instr_i[15:8]};
  assign known = (key == 9'h001) || (key == 9'h002) || (key == 9'h003) ||
                 (key == 9'h048) || (key == 9'h005) || (key == 9'h008) ||
                 (key == 9'h10A) || (key == 9'h0B5) || (key == 9'h0B3) ||
                 (key == 9'h0B7) || (key == 9'h0B9);

  assert_set_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && key == 9'h001 |=> enable_o);
  assert_clr_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && key == 9'h002 |=> !enable_o);
  assert_load_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && key == 9'h003 |=> enable_o == $past(mem_bits[instr_i[ADDR_W-1:0]]));
  assert_store_ungated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && key == 9'h0B5 |=> mem_bits[$past(instr_i[ADDR_W-1:0])] == $past(enable_o));
  assert_unknown_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !known |=> err_o && enable_o == $past(enable_o));
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_idle_mem_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i && !host_we_i |=> $stable(mem_bits));
  assert_carry_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_carry_we_i |=> $stable(carry_o));
endmodule

bind pe_enable_unit pe_enable_unit_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .instr_valid_i   (instr_valid_i),
  .instr_i         (instr_i),
  .host_we_i       (host_we_i),
  .host_carry_we_i (host_carry_we_i),
  .enable_o        (enable_o),
  .carry_o         (carry_o),
  .err_o           (err_o),
  .mem_bits        (mem_bits)
);

// File: tb/pe_enable_unit_tb_top.sv
module pe_enable_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        host_we_i = 1'b0;
  logic [7:0]  host_addr_i = '0;
  logic        host_wdata_i = 1'b0;
  logic        host_rdata_o;
  logic        host_carry_we_i = 1'b0;
  logic        host_carry_i = 1'b0;
  logic        enable_o, carry_o, err_o;

  int checks = 0;
  int fails = 0;
  bit m_mem [256];
  bit m_en, m_cry, m_err;

  always #10 clk_i = ~clk_i;

  pe_enable_unit dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit known(input logic [31:0] w);
    logic [8:0] k;
    k = {w[16], w[15:8]};
    return k inside {9'h001, 9'h002, 9'h003, 9'h048, 9'h005, 9'h008,
                     9'h10A, 9'h0B5, 9'h0B3, 9'h0B7, 9'h0B9};
  endfunction

  function automatic void model(input bit v, input logic [31:0] w, input bit hwe,
                                input logic [7:0] ha, input bit hwd,
                                input bit cwe, input bit cv);
    logic [8:0] k;
    logic [7:0] a;
    bit b, e, c;
    k = {w[16], w[15:8]};
    a = w[7:0];
    b = m_mem[a];
    e = m_en;
    c = m_cry;
    if (hwe) m_mem[ha] = hwd;
    if (v) begin
      case (k)
        9'h001: m_en = 1'b1;
        9'h002: m_en = 1'b0;
        9'h003: m_en = b;
        9'h048: m_en = !b;
        9'h005: m_en = e & b;
        9'h008: m_en = e & !b;
        9'h10A: m_en = e ^ b;
        9'h0B5: m_mem[a] = e;
        9'h0B3: m_mem[a] = c;
        9'h0B7: m_mem[a] = b | e;
        9'h0B9: m_mem[a] = b & e;
        default: m_err = 1'b1;
      endcase
    end
    if (cwe) m_cry = cv;
  endfunction

  task automatic step(input bit v, input logic [31:0] w, input bit hwe = 0,
                      input logic [7:0] ha = 0, input bit hwd = 0,
                      input bit cwe = 0, input bit cv = 0);
    @(negedge clk_i);
    instr_valid_i = v; instr_i = w; host_we_i = hwe; host_addr_i = ha;
    host_wdata_i = hwd; host_carry_we_i = cwe; host_carry_i = cv;
    @(posedge clk_i);
    model(v, w, hwe, ha, hwd, cwe, cv);
    #2;
    host_we_i = 1'b0; host_carry_we_i = 1'b0; instr_valid_i = 1'b0;
  endtask

  task automatic ins(input logic [31:0] w);
    step(1'b1, w);
  endtask

  task automatic chk_state(input string req);
    check(enable_o == m_en, req, "enable", enable_o, m_en);
    check(err_o == m_err, req, "err", err_o, m_err);
    check(carry_o == m_cry, req, "carry", carry_o, m_cry);
  endtask

  task automatic chk_bit(input string req, input logic [7:0] a);
    host_we_i = 1'b0;
    host_addr_i = a;
    #1;
    check(host_rdata_o == m_mem[a], req, $sformatf("bit %0d", a), host_rdata_o, m_mem[a]);
  endtask

  initial begin
    int nz;
    bit old_en;
    void'($urandom(32'h5eed_0042));
    foreach (m_mem[i]) m_mem[i] = 1'b0;
    m_en = 1'b1; m_cry = 1'b0; m_err = 1'b0;
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    #5;
    // R1 reset state
    chk_state("R1");
    nz = 0;
    for (int i = 0; i < 256; i++) begin
      host_addr_i = 8'(i);
      #1;
      if (host_rdata_o !== 1'b0) nz++;
    end
    check(nz == 0, "R1", "nonzero bits after reset", nz, 0);

    // R11 host write, read back, carry preset
    step(1'b0, 32'h0, 1'b1, 8'd5, 1'b1, 1'b1, 1'b1);
    chk_bit("R11", 8'd5);
    check(carry_o == 1'b1, "R11", "carry preset", carry_o, 1);

    // R3 load and inverted load
    ins(32'h0305); chk_state("R3");
    ins(32'h4805); chk_state("R3");
    ins(32'h0306); chk_state("R3");
    check(enable_o == 1'b0, "R3", "load of zero bit", enable_o, 0);

    // R2 set/clear
    ins(32'h0100); chk_state("R2");
    check(enable_o == 1'b1, "R2", "set", enable_o, 1);
    ins(32'h0200); chk_state("R2");
    check(enable_o == 1'b0, "R2", "clear", enable_o, 0);

    // R4 and / and-inverse
    ins(32'h0100); ins(32'h0505); chk_state("R4");
    check(enable_o == 1'b1, "R4", "and with 1", enable_o, 1);
    ins(32'h0805); chk_state("R4");
    check(enable_o == 1'b0, "R4", "and with ~1", enable_o, 0);

    // R5 xor with bit 16 set
    ins(32'h0100); ins(32'h10A05); chk_state("R5");
    check(enable_o == 1'b0, "R5", "xor 1^1", enable_o, 0);
    ins(32'h10A06); chk_state("R5");

    // R6 stores ungated while enable is 0
    ins(32'h0200);
    ins(32'hB505); chk_bit("R6", 8'd5);
    check(host_rdata_o == 1'b0, "R6", "store enable while gated off", host_rdata_o, 0);
    ins(32'hB311); chk_bit("R6", 8'd17);
    check(host_rdata_o == 1'b1, "R6", "store carry", host_rdata_o, 1);

    // R7 or/and into memory, ungated
    ins(32'hB711); chk_bit("R7", 8'd17);
    ins(32'hB911); chk_bit("R7", 8'd17);
    check(host_rdata_o == 1'b0, "R7", "and-into with enable 0", host_rdata_o, 0);
    ins(32'h0100); ins(32'hB712); chk_bit("R7", 8'd18);
    check(host_rdata_o == 1'b1, "R7", "or-into with enable 1", host_rdata_o, 1);

    // R10 back-to-back and idle word
    ins(32'hB514); ins(32'h4814); chk_state("R10");
    check(enable_o == 1'b0, "R10", "next instruction sees store", enable_o, 0);
    step(1'b0, 32'h0100); chk_state("R10");
    check(enable_o == 1'b0, "R10", "invalid word ignored", enable_o, 0);

    // R8 upper bits ignored
    ins(32'hFFFE_0100); chk_state("R8");
    check(enable_o == 1'b1, "R8", "upper bits ignored", enable_o, 1);

    // R12 collisions
    ins(32'h0200);
    step(1'b1, 32'hB51E, 1'b1, 8'd30, 1'b1); chk_bit("R12", 8'd30);
    check(host_rdata_o == 1'b0, "R12", "instruction write wins", host_rdata_o, 0);
    step(1'b1, 32'h031F, 1'b1, 8'd31, 1'b1); chk_state("R12");
    check(enable_o == 1'b0, "R12", "load sees old bit", enable_o, 0);
    chk_bit("R12", 8'd31);

    // R9 / R5 / R8 unknown forms
    old_en = m_en;
    ins(32'h0A05); chk_state("R5");
    check(err_o == 1'b1, "R5", "0x0A without bit 16 is unknown", err_o, 1);
    ins(32'h10305); chk_state("R8");
    ins(32'h771F); chk_state("R9");
    check(enable_o == old_en, "R9", "unknown keeps enable", enable_o, old_en);
    chk_bit("R9", 8'd31);
    ins(32'h0100); chk_state("R9");
    check(err_o == 1'b1, "R9", "err sticky", err_o, 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [8:0] keys [11] = '{9'h001, 9'h002, 9'h003, 9'h048, 9'h005, 9'h008,
                                 9'h10A, 9'h0B5, 9'h0B3, 9'h0B7, 9'h0B9};
      logic [31:0] w;
      logic [8:0] k;
      logic [7:0] a, ha;
      bit hwe;
      a = 8'($urandom_range(0, 63));
      k = keys[$urandom_range(0, 10)];
      w = {15'($urandom), k, a};
      if ($urandom_range(0, 39) == 0) w = $urandom;
      hwe = ($urandom_range(0, 4) == 0);
      ha = ($urandom_range(0, 1) == 0) ? a : 8'($urandom_range(0, 63));
      step($urandom_range(0, 7) != 0, w, hwe, ha, 1'($urandom),
           $urandom_range(0, 9) == 0, 1'($urandom));
      chk_state(known(w) ? "R10" : "R9");
      chk_bit("R12", 8'($urandom_range(0, 63)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule